// File: doc/BRIEF.md
# Four-Entry Master Data Stash

This block is a byte-wide first-in first-out store with four entries. It sits between a host register port and an I2C master transfer engine. The host appends a byte by writing the data register and takes the oldest byte by reading it. The transfer engine can overwrite all four entries and the fill level in one load, for example after it has received bytes from the bus.

Two sticky status flags, "has data" and "full", are set and cleared on specific events. They are not decoded from the level. As a result, an engine load for a write transfer can change the level and leave both flags as they were. A flush input empties the store. Reading an empty store returns 0xFF and changes nothing. Writing to a full store is dropped without any indication.

Top module: `mdb_stash`

## Requirements
- R1: After reset the level is 0, both flags are 0, and `host_rdata` shows 0xFF.
- R2: A host read while the level is 0 sees 0xFF on `host_rdata`. The level and both flags stay unchanged.
- R3: Host reads return bytes in the order they were written. Each accepted write raises the level by one, and each read of a non-empty store lowers it by one.
- R4: A host write while the level is 4 is dropped. The level stays at 4 and the stored bytes are unchanged.
- R5: A host write into an empty store sets `has_data`. The write that brings the level to 4 sets `full`.
- R6: A host read taken at level 4 clears `full`. A host read taken at level 1 clears `has_data`.
- R7: A `flush` pulse sets the level to 0, zeroes every entry and clears both flags.
- R8: An `eng_load` pulse replaces all entries with `eng_data` and sets the level to `eng_count`. Bits 7:0 hold the byte returned first. A count above 4 is taken as 4.
- R9: When `eng_is_read` is 1, a load with a count of 1 or more sets `has_data`, and a count of 4 sets `full`. When `eng_is_read` is 0, or the count is 0, the load leaves both flags unchanged.
- R10: Precedence runs from `eng_load`, to `flush`, to host access. When read and write occur in the same cycle, the read is performed and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe (push) |
| host_wdata | input | 8 | Byte to push |
| host_rd | input | 1 | Host read strobe (pop) |
| host_rdata | output | 8 | Oldest byte, or 0xFF when empty |
| flush | input | 1 | Empty the store and clear the flags |
| eng_load | input | 1 | Engine bulk-load strobe |
| eng_data | input | 32 | Four bytes, with the first-out byte in bits 7:0 |
| eng_count | input | 3 | Number of valid loaded bytes, 0 to 4 |
| eng_is_read | input | 1 | The loaded transfer was a bus read |
| level | output | 3 | Current fill level, 0 to 4 |
| has_data | output | 1 | Sticky "has data" flag |
| full | output | 1 | Sticky "full" flag |

## Verification
The hardest states to reach are those where the flags and the level disagree. One example is a store holding two bytes after a write-transfer load, with both flags clear. Another is a load with a count of 7, which must be clamped. These states cannot be reached by host pushes alone. The stimulus therefore flushes first, then drives engine loads with `eng_is_read` low and with an out-of-range count. It then drains the store and watches that reads still come out in order while the flags follow only the events listed in R6. Same-cycle collisions of load, flush and host strobes are driven on purpose to exercise the precedence in R10.

// File: rtl/mdb_stash.sv
module mdb_stash #(
  parameter int W         = 8,
  parameter int DEPTH     = 4,
  parameter int EMPTY_VAL = 255
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_wr,
  input  logic [W-1:0]               host_wdata,
  input  logic                       host_rd,
  output logic [W-1:0]               host_rdata,
  input  logic                       flush,
  input  logic                       eng_load,
  input  logic [W*DEPTH-1:0]         eng_data,
  input  logic [$clog2(DEPTH+1)-1:0] eng_count,
  input  logic                       eng_is_read,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       has_data,
  output logic                       full
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] TOP = CW'(DEPTH);

  logic [W-1:0]  slot [DEPTH];
  logic [CW-1:0] lvl;
  logic          has_q, full_q;
  logic [CW-1:0] ld_cnt;
  logic          do_rd, do_wr;

  assign ld_cnt = (eng_count > TOP) ? TOP : eng_count;
  assign do_rd  = host_rd && !eng_load && !flush && (lvl != '0);
  assign do_wr  = host_wr && !host_rd && !eng_load && !flush && (lvl != TOP);

  assign host_rdata = (lvl == '0) ? W'(EMPTY_VAL) : slot[0];
  assign level      = lvl;
  assign has_data   = has_q;
  assign full       = full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl    <= '0;
      has_q  <= 1'b0;
      full_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (eng_load) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= eng_data[i*W +: W];
      lvl <= ld_cnt;
      if (eng_is_read) begin
        if (ld_cnt != '0) has_q  <= 1'b1;
        if (ld_cnt == TOP) full_q <= 1'b1;
      end
    end else if (flush) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
      lvl    <= '0;
      has_q  <= 1'b0;
      full_q <= 1'b0;
    end else if (do_rd) begin
      for (int i = 0; i < DEPTH-1; i++) slot[i] <= slot[i+1];
      slot[DEPTH-1] <= '0;
      lvl <= lvl - 1'b1;
      if (lvl == TOP)       full_q <= 1'b0;
      if (lvl == CW'(1))    has_q  <= 1'b0;
    end else if (do_wr) begin
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i) == lvl) slot[i] <= host_wdata;
      lvl <= lvl + 1'b1;
      if (lvl == TOP - 1'b1) full_q <= 1'b1;
      if (lvl == '0)         has_q  <= 1'b1;
    end
  end

  p_empty_read_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && lvl == '0 && !eng_load && !flush
    |=> lvl == '0 && has_q == $past(has_q) && full_q == $past(full_q));

  p_push_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !host_rd && lvl < TOP && !eng_load && !flush
    |=> lvl == $past(lvl) + 1'b1);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !host_rd && lvl == TOP && !eng_load && !flush
    |=> lvl == TOP && slot[DEPTH-1] == $past(slot[DEPTH-1]) && slot[0] == $past(slot[0]));

  p_first_push_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !host_rd && lvl == '0 && !eng_load && !flush |=> has_q);

  p_last_pop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && lvl == CW'(1) && !eng_load && !flush |=> !has_q && lvl == '0);

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !eng_load |=> lvl == '0 && !has_q && !full_q && slot[0] == '0);

  p_load_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_load |=> lvl == $past(ld_cnt) && lvl <= TOP);

  p_write_load_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_load && !eng_is_read |=> $stable(has_q) && $stable(full_q));

  p_load_beats_host_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_load && (flush || host_rd || host_wr) |=> slot[0] == $past(eng_data[W-1:0]));
endmodule

// File: tb/mdb_stash_tb.sv
module mdb_stash_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, flush = 0, eng_load = 0, eng_is_read = 0;
  logic [7:0] host_wdata = 0;
  logic [31:0] eng_data = 0;
  logic [2:0] eng_count = 0;
  logic [7:0] host_rdata;
  logic [2:0] level;
  logic has_data, full;

  always #10 clk = ~clk;

  mdb_stash dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .flush(flush),
    .eng_load(eng_load), .eng_data(eng_data), .eng_count(eng_count),
    .eng_is_read(eng_is_read), .level(level), .has_data(has_data), .full(full)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [7:0] sb_val[$];
  string sb_tag[$];
  logic [7:0] m[$];
  bit m_has = 0, m_full = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      if (host_rd && rst_n) begin
        if (sb_val.size() == 0) chk(0, "R3 unexpected read", int'(host_rdata), 0);
        else begin
          automatic logic [7:0] e = sb_val.pop_front();
          automatic string t = sb_tag.pop_front();
          chk(host_rdata == e, t, int'(host_rdata), int'(e));
        end
      end
    end
  end

  task automatic step(input bit wr, input logic [7:0] wd, input bit rd, input bit fl,
                      input bit ld, input logic [31:0] ldd, input logic [2:0] ldc,
                      input bit ldr, input string tag);
    host_wr = wr; host_wdata = wd; host_rd = rd; flush = fl;
    eng_load = ld; eng_data = ldd; eng_count = ldc; eng_is_read = ldr;
    if (rd) begin
      sb_val.push_back(m.size() == 0 ? 8'hFF : m[0]);
      sb_tag.push_back(tag);
    end
    if (ld) begin
      automatic int n = (ldc > 4) ? 4 : int'(ldc);
      m.delete();
      for (int i = 0; i < n; i++) m.push_back(ldd[i*8 +: 8]);
      if (ldr && n != 0) m_has = 1;
      if (ldr && n == 4) m_full = 1;
    end else if (fl) begin
      m.delete(); m_has = 0; m_full = 0;
    end else if (rd) begin
      if (m.size() != 0) begin
        if (m.size() == 4) m_full = 0;
        if (m.size() == 1) m_has = 0;
        void'(m.pop_front());
      end
    end else if (wr && m.size() < 4) begin
      if (m.size() == 0) m_has = 1;
      m.push_back(wd);
      if (m.size() == 4) m_full = 1;
    end
    @(negedge clk);
    host_wr = 0; host_rd = 0; flush = 0; eng_load = 0; eng_is_read = 0;
    chk(level == 3'(m.size()), {tag, " level"}, int'(level), m.size());
    chk(has_data == m_has, {tag, " has_data"}, int'(has_data), int'(m_has));
    chk(full == m_full, {tag, " full"}, int'(full), int'(m_full));
  endtask

  task automatic push(input logic [7:0] d, input string t); step(1, d, 0, 0, 0, 0, 0, 0, t); endtask
  task automatic pop(input string t); step(0, 0, 1, 0, 0, 0, 0, 0, t); endtask

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(level == 0 && !has_data && !full, "R1 reset state", int'({has_data, full, level}), 0);
    chk(host_rdata == 8'hFF, "R1 idle rdata", int'(host_rdata), 8'hFF);
    @(negedge clk);
    pop("R2 empty read");
    push(8'hA1, "R5 first push");
    push(8'hB2, "R3 push");
    push(8'hC3, "R3 push");
    pop("R3 order");
    push(8'hD4, "R3 push");
    push(8'hE5, "R5 full push");
    push(8'h77, "R4 drop when full");
    pop("R6 pop at full");
    pop("R3 order");
    pop("R3 order");
    pop("R6 last pop");
    pop("R2 empty again");
    push(8'h11, "R5 push");
    step(1, 8'h22, 1, 0, 0, 0, 0, 0, "R10 read+write");
    push(8'h33, "R3 push");
    push(8'h44, "R3 push");
    push(8'h55, "R3 push");
    step(0, 0, 0, 1, 0, 0, 0, 0, "R7 flush");
    pop("R7 empty after flush");
    step(1, 8'h66, 0, 1, 0, 0, 0, 0, "R10 flush beats write");
    step(0, 0, 0, 0, 1, 32'h4433_2211, 3'd4, 1, "R9 read load full");
    pop("R8 load order");
    pop("R8 load order");
    step(0, 0, 0, 1, 0, 0, 0, 0, "R7 flush");
    step(0, 0, 0, 0, 1, 32'h0000_BBAA, 3'd2, 0, "R9 write load keeps flags");
    pop("R8 write load order");
    pop("R9 last pop");
    step(0, 0, 0, 0, 1, 32'hDDCC_BBAA, 3'd7, 1, "R8 count clamp");
    step(0, 0, 1, 0, 1, 32'h0403_0201, 3'd3, 0, "R10 load beats read");
    step(1, 8'h99, 0, 1, 1, 32'h0000_00F0, 3'd1, 1, "R10 load beats flush");
    step(0, 0, 0, 0, 1, 32'h0000_0000, 3'd0, 1, "R9 zero count load");
    pop("R2 empty after zero load");
    repeat (3) @(negedge clk);
    chk(sb_val.size() == 0, "R3 scoreboard drained", sb_val.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule